// File: doc/BRIEF.md
# Staggered Group Output Switcher

This block sits between a channel-enable store and a bank of sixteen channel drivers. Instead of passing a new enable word to all channels on one clock edge, it walks through the channels in nine fixed groups. Each group switches a programmable number of clock cycles after the one before it. The sum of the switched currents therefore ramps up or down in steps, rather than moving all at once.

The first group is channel 0 alone. The next seven groups each pair a channel from the low end of the bank with its mirror from the high end. The last group is channel 8 alone. A walk starts when the blank level changes in either direction, and when the latched word is updated while blank is low. When the walk ends, each output equals its latched bit, forced low while blank is high. A trigger that arrives during a walk restarts it from the first group, using the newest word.

Top module: `stag_switch`

## Requirements
- R1: While reset is asserted, and after its release until the first trigger, `drive_o` is 0 and `busy_o` is 0.
- R2: Group membership is fixed. Group 0 holds channel 0. Group g, for g = 1 to 7, holds channels g and 16−g. Group 8 holds channel 8. A single update never changes bits that belong to more than one group.
- R3: A change of `blank_i` in either direction, seen on a clock edge, starts a walk.
- R4: A `latch_i` pulse starts a walk only while `blank_i` is low. A pulse while `blank_i` is high leaves `drive_o` unchanged and `busy_o` low.
- R5: At the end of a walk, `drive_o` equals the value of `target_i & ~{16{blank_i}}` sampled on the trigger edge.
- R6: Let T be the edge that samples the trigger, and STEP the delay parameter (default 1). Group g takes its new value on edge T+(g+1)·STEP. `drive_o` changes on no other edge. `busy_o` is 1 from edge T until edge T+9·STEP, where it returns to 0.
- R7: A trigger during a walk restarts the walk from group 0 with the new word, and no group is updated on that edge. Groups already updated keep their values until the new walk reaches them.
- R8: A change of `target_i` without a trigger has no effect on `drive_o` or `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_i | input | 16 | Latched channel-enable word |
| blank_i | input | 1 | High forces all channels off |
| latch_i | input | 1 | One-cycle strobe marking an update of `target_i` |
| drive_o | output | 16 | Staggered channel drive word |
| busy_o | output | 1 | High while a walk is in progress |

## Verification
The trigger is registered on edge T, and both the goal word and `busy_o` appear right after that edge. Group g of `drive_o` moves on edge T+(g+1)·STEP, so with the bench's STEP of 2 the full walk spans 18 edges. The bench drives its inputs on the falling edge. It then samples `drive_o` and `busy_o` at every following falling edge, from k = 0 to k = 9·STEP after T. Each sample is compared with a word built from the old value, the new value and the number of groups due by that edge. A skipped, early or late group is therefore caught in the exact cycle where it goes wrong.

// File: rtl/stag_pkg.sv
package stag_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/stag_trig.sv
// Trigger detection: blank edges in either direction, or a latch strobe while unblanked.
module stag_trig #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] target_i,
  input  logic           blank_i,
  input  logic           latch_i,
  output logic           trig_o,
  output logic [NCH-1:0] goal_o
);
  logic blank_q;
  logic blank_chg;

  assign blank_chg = blank_i ^ blank_q;
  assign trig_o    = blank_chg | (latch_i & ~blank_i);
  assign goal_o    = target_i & ~{NCH{blank_i}};

  // reset to blanked so that an unblanked start is seen as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
    end else if (blank_chg) begin
      blank_q <= blank_i;
    end
  end
endmodule

// File: rtl/stag_seq.sv
// Group walker: one update pulse every STEP cycles, for NGRP groups.
module stag_seq
  import stag_pkg::*;
#(
  parameter int NGRP = 9,
  parameter int STEP = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_i,
  output logic [$clog2(NGRP)-1:0] grp_o,
  output logic                    apply_o,
  output logic                    busy_o
);
  localparam int GW = $clog2(NGRP);
  localparam int CW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [GW-1:0] LAST_GRP = GW'(NGRP - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(STEP - 1);

  seq_state_e    state_q, state_d;
  logic [GW-1:0] grp_q, grp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          apply;

  always_comb begin
    state_d = state_q;
    grp_d   = grp_q;
    cnt_d   = cnt_q;
    apply   = 1'b0;
    if (trig_i) begin
      state_d = SEQ_RUN;
      grp_d   = '0;
      cnt_d   = '0;
    end else if (state_q == SEQ_RUN) begin
      if (cnt_q == LAST_CNT) begin
        apply = 1'b1;
        cnt_d = '0;
        if (grp_q == LAST_GRP) begin
          state_d = SEQ_IDLE;
        end else begin
          grp_d = grp_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      grp_q   <= '0;
      cnt_q   <= '0;
    end else if (trig_i || state_q == SEQ_RUN) begin
      state_q <= state_d;
      grp_q   <= grp_d;
      cnt_q   <= cnt_d;
    end
  end

  assign grp_o   = grp_q;
  assign apply_o = apply;
  assign busy_o  = (state_q == SEQ_RUN);
endmodule

// File: rtl/stag_mask.sv
// Decodes a group index into the channel bits it owns (mirror pairing).
module stag_mask #(
  parameter int NCH  = 16,
  parameter int NGRP = NCH / 2 + 1
) (
  input  logic [$clog2(NGRP)-1:0] grp_i,
  output logic [NCH-1:0]          mask_o
);
  localparam int GW = $clog2(NGRP);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int OWNER = (c <= NCH / 2) ? c : NCH - c;
    assign mask_o[c] = (grp_i == GW'(OWNER));
  end
endmodule

// File: rtl/stag_switch.sv
module stag_switch #(
  parameter int NCH  = 16,
  parameter int STEP = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] target_i,
  input  logic           blank_i,
  input  logic           latch_i,
  output logic [NCH-1:0] drive_o,
  output logic           busy_o
);
  localparam int NGRP = NCH / 2 + 1;
  localparam int GW   = $clog2(NGRP);

  logic           trig;
  logic [NCH-1:0] goal_in;
  logic [NCH-1:0] goal_q;
  logic [GW-1:0]  grp;
  logic           apply;
  logic [NCH-1:0] mask;
  logic [NCH-1:0] drive_q, drive_d;

  stag_trig #(.NCH(NCH)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .target_i (target_i),
    .blank_i  (blank_i),
    .latch_i  (latch_i),
    .trig_o   (trig),
    .goal_o   (goal_in)
  );

  stag_seq #(.NGRP(NGRP), .STEP(STEP)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig),
    .grp_o   (grp),
    .apply_o (apply),
    .busy_o  (busy_o)
  );

  stag_mask #(.NCH(NCH), .NGRP(NGRP)) u_mask (
    .grp_i  (grp),
    .mask_o (mask)
  );

  always_comb begin
    drive_d = (drive_q & ~mask) | (goal_q & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goal_q <= '0;
    end else if (trig) begin
      goal_q <= goal_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
    end else if (apply) begin
      drive_q <= drive_d;
    end
  end

  assign drive_o = drive_q;
endmodule

// File: rtl/stag_switch_chk.sv
module stag_switch_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           blank_i,
  input logic           latch_i,
  input logic           trig,
  input logic           busy_o,
  input logic [NCH-1:0] drive_o
);
  // R6: the output holds when no walk is running and nothing fires
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !trig) |=> $stable(drive_o));

  // R3: every trigger leaves a walk in progress on the next cycle
  p_busy_after_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy_o);

  // R4: a latch strobe under a steady high blank starts nothing
  p_latch_blanked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && blank_i && $past(blank_i) && !busy_o) |=> !busy_o);

  // R2: one update touches at most the two channels of one group
  p_one_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drive_o ^ $past(drive_o)) <= 2);

  // R5: a settled, steadily blanked bank is fully off
  p_blank_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_i && $past(blank_i) && !busy_o) |-> (drive_o == '0));
endmodule

bind stag_switch stag_switch_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .blank_i (blank_i),
  .latch_i (latch_i),
  .trig    (trig),
  .busy_o  (busy_o),
  .drive_o (drive_o)
);

// File: tb/stag_switch_bench.sv
module stag_switch_bench;
  localparam int STEP = 2;
  localparam int NG   = 9;

  logic        clk;
  logic        rst_n;
  logic [15:0] target_i;
  logic        blank_i;
  logic        latch_i;
  logic [15:0] drive_o;
  logic        busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  stag_switch #(.NCH(16), .STEP(STEP)) u_stag_switch (
    .clk      (clk),
    .rst_n    (rst_n),
    .target_i (target_i),
    .blank_i  (blank_i),
    .latch_i  (latch_i),
    .drive_o  (drive_o),
    .busy_o   (busy_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // group index of a channel, written from R2
  function automatic int grp_of(input int c);
    if (c == 0) return 0;
    if (c == 8) return 8;
    if (c < 8) return c;
    return 16 - c;
  endfunction

  // word after the first n groups have moved from start to goal
  function automatic logic [15:0] mix(input logic [15:0] s, input logic [15:0] g, input int n);
    logic [15:0] r;
    for (int c = 0; c < 16; c++) r[c] = (grp_of(c) < n) ? g[c] : s[c];
    return r;
  endfunction

  task automatic fire(input logic b, input logic [15:0] tgt, input logic lat);
    @(negedge clk);
    blank_i  = b;
    target_i = tgt;
    latch_i  = lat;
    @(posedge clk);
    #1 latch_i = 1'b0;
  endtask

  // samples at negedges k = 0..kmax after the trigger edge T (R6 timing)
  task automatic expect_seq(input string req, input logic [15:0] s, input logic [15:0] g, input int kmax);
    for (int k = 0; k <= kmax; k++) begin
      int n;
      @(negedge clk);
      n = (k / STEP > NG) ? NG : k / STEP;
      check({req, " R6 drive"}, drive_o, mix(s, g, n));
      check({req, " R6 busy"}, {15'b0, busy_o}, {15'b0, (k < NG * STEP)});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; blank_i = 1'b1; latch_i = 1'b0; target_i = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 drive in reset", drive_o, 16'h0);
    check("R1 busy in reset", {15'b0, busy_o}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 drive after reset", drive_o, 16'h0);
    check("R1 busy after reset", {15'b0, busy_o}, 16'h0);
  endtask

  task automatic t_latch_blanked();
    fire(1'b1, 16'hA5C3, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4 blanked latch drive", drive_o, 16'h0);
      check("R4 blanked latch busy", {15'b0, busy_o}, 16'h0);
    end
  endtask

  task automatic t_unblank();
    fire(1'b0, 16'hA5C3, 1'b0);
    expect_seq("R3 R2 fall", 16'h0, 16'hA5C3, NG * STEP);
    check("R5 unblank final", drive_o, 16'hA5C3);
  endtask

  task automatic t_relatch();
    fire(1'b0, 16'h3C96, 1'b1);
    expect_seq("R4 relatch", 16'hA5C3, 16'h3C96, NG * STEP);
    check("R5 relatch final", drive_o, 16'h3C96);
  endtask

  task automatic t_no_latch();
    @(negedge clk);
    target_i = 16'h5A5A;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R8 drive kept", drive_o, 16'h3C96);
      check("R8 busy low", {15'b0, busy_o}, 16'h0);
    end
  endtask

  task automatic t_blank();
    fire(1'b1, 16'h3C96, 1'b0);
    expect_seq("R3 rise", 16'h3C96, 16'h0, NG * STEP);
    check("R5 blank final", drive_o, 16'h0);
  endtask

  task automatic t_restart();
    fire(1'b0, 16'hFFFF, 1'b0);
    expect_seq("R7 first", 16'h0, 16'hFFFF, 4);
    // the next trigger lands on edge T+6: groups 0 and 1 have moved
    fire(1'b0, 16'h0F0F, 1'b1);
    expect_seq("R7 restart", mix(16'h0, 16'hFFFF, 2), 16'h0F0F, NG * STEP);
    check("R7 final", drive_o, 16'h0F0F);
  endtask

  initial begin
    t_reset();
    t_latch_blanked();
    t_unblank();
    t_relatch();
    t_no_latch();
    t_blank();
    t_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule